// File: doc/BRIEF.md
# Switchable Instruction-Encoding Selector

This block belongs to one hart. It holds a writable pair of identifier registers, a vendor code and an architecture code, and uses that pair to choose which of several instruction decode engines interprets the incoming instruction bits. Each supported pair stands for one complete binary-encoding interpretation. Examples are a legacy revision of the standard encoding, a current revision, or a foreign instruction set. The decoders themselves sit outside the block. Each decoder takes one bit of the one-hot `dec_en` vector as an extra term in its encoding-match AND gate, so at most one engine ever claims a given encoding.

Writes to the identifier registers are write-any-read-legal. The block forms the pair that would result from a write and looks it up in a parameterized table of supported pairs. If the pair is in the table, the block adopts it and also switches the trap-vector base to the handler set written for that encoding. If the pair is not in the table, the write is dropped. The block changes only which decoder is selected and never touches any extension's state. After a switch it raises a stall request for a fixed number of cycles so that the pipeline can drain instructions decoded under the old interpretation. Trap entry leaves the pair as it is, so a handler can read it out as part of the context. A context restore loads a saved pair back in one step. When the block is built read-only, it stays on table entry 0 for good.

Top module: `enc_select_ctrl`

## Requirements
- R1: After synchronous reset the block selects table entry 0: `dec_en` is 1 (bit 0 only), `trap_base` equals entry 0's base, and `switch_stall` is low.
- R2: Table entry i holds vendor code `VENDOR_BASE + i/2` (integer division), architecture code `i`, and trap base `TVEC_BASE + i*TVEC_STRIDE`. With the default parameters these are vendor 0x0A00 + i/2, architecture i, and base 0x1000_0000 + 0x100*i.
- R3: `dec_en` has exactly one bit set in every cycle after reset, and that bit is the index of the selected entry.
- R4: A CSR write with `csr_sel` = 2 supplies the whole pair in `csr_wdata`, with the vendor in bits [31:16] and the architecture in bits [15:0]. If that pair is in the table, `dec_en` and `trap_base` show the new entry from the next cycle on.
- R5: `csr_sel` = 0 writes only the vendor code from `csr_wdata[15:0]`, and `csr_sel` = 1 writes only the architecture code from `csr_wdata[15:0]`. The other half keeps its current value. The write is accepted when the resulting pair is in the table.
- R6: A write or restore whose resulting pair is not in the table, or a write with `csr_sel` = 3, is ignored. The previous selection, its trap base and a low stall all stay as they were.
- R7: An accepted update that changes the selected entry holds `switch_stall` high for exactly `STALL_CYCLES` cycles, starting in the cycle the new selection appears. An accepted update that leaves the entry unchanged does not raise the stall.
- R8: While `trap_enter` is high, the pair does not change. Any CSR write or restore presented in the same cycle is dropped.
- R9: `ctx_restore` loads the pair from `ctx_pair` (same layout as R4) under the same legality rule. It wins over a CSR write presented in the same cycle.
- R10: `csr_rdata` returns the selected pair, chosen combinationally by `csr_sel`: 0 gives the vendor code zero-extended, 1 gives the architecture code zero-extended, 2 gives the packed pair as in R4, and 3 gives zero.
- R11: When `WRITABLE` is 0, every write and restore is ignored and the block stays on entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 2 | CSR select: 0 vendor, 1 architecture, 2 packed pair, 3 none |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for `csr_sel` |
| trap_enter | input | 1 | Trap entry this cycle; freezes the pair |
| ctx_restore | input | 1 | Load `ctx_pair` as the new pair |
| ctx_pair | input | 32 | Saved pair to restore, vendor in [31:16] |
| dec_en | output | NUM_SETS | One-hot decode-engine enable |
| trap_base | output | TVEC_W | Trap-vector base of the active encoding set |
| switch_stall | output | 1 | Pipeline stall request while a switch settles |

## Verification
The bench steps the pair through every table entry and checks the enable bit and trap base of each one. A lookup that is shifted or decoded wrongly would light the wrong engine. It then writes single fields where half of the pair moves to a legal entry and half lands on an illegal one. A design that legalized each half on its own, or that took unknown pairs, would change the selection or raise a stall when it should not. It counts the stall cycles after a real switch and after a write of the same pair, which exposes off-by-one timers and stalls raised for no change. Trap-entry and restore collisions with a CSR write in the same cycle show whether the priority is wrong. A read-only copy of the block shows whether writes leak through.

// File: rtl/enc_sel_pkg.sv
package enc_sel_pkg;

    localparam int ID_W   = 16;
    localparam int PAIR_W = 2 * ID_W;

    typedef struct packed {
        logic [ID_W-1:0] vendor;
        logic [ID_W-1:0] arch;
    } id_pair_t;

    typedef enum logic [1:0] {
        SEL_VENDOR = 2'd0,
        SEL_ARCH   = 2'd1,
        SEL_PAIR   = 2'd2,
        SEL_NONE   = 2'd3
    } csr_sel_e;

    // Supported pair at table index idx: entries come in vendor groups of two.
    function automatic id_pair_t entry_pair(input logic [ID_W-1:0] vbase,
                                            input int unsigned      idx);
        id_pair_t p;
        p.vendor = vbase + ID_W'(idx >> 1);
        p.arch   = ID_W'(idx);
        return p;
    endfunction

endpackage

// File: rtl/enc_match.sv
module enc_match
    import enc_sel_pkg::*;
#(
    parameter int              NUM_SETS    = 4,
    parameter int              IDX_W       = 2,
    parameter logic [ID_W-1:0] VENDOR_BASE = 16'h0A00
) (
    input  id_pair_t         cand,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [NUM_SETS-1:0] eq;

    generate
        for (genvar g = 0; g < NUM_SETS; g++) begin : g_cmp
            assign eq[g] = (cand == entry_pair(VENDOR_BASE, g));
        end
    endgenerate

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = NUM_SETS - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/enc_vec_table.sv
module enc_vec_table #(
    parameter int                NUM_SETS    = 4,
    parameter int                IDX_W       = 2,
    parameter int                TVEC_W      = 32,
    parameter logic [TVEC_W-1:0] TVEC_BASE   = 32'h1000_0000,
    parameter logic [TVEC_W-1:0] TVEC_STRIDE = 32'h0000_0100
) (
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_SETS-1:0] onehot,
    output logic [TVEC_W-1:0]   base
);

    logic [TVEC_W-1:0] bases [NUM_SETS];

    generate
        for (genvar g = 0; g < NUM_SETS; g++) begin : g_row
            assign bases[g]  = TVEC_BASE + TVEC_W'(g) * TVEC_STRIDE;
            assign onehot[g] = (idx == IDX_W'(g));
        end
    endgenerate

    assign base = bases[idx];

endmodule

// File: rtl/enc_stall_timer.sv
module enc_stall_timer #(
    parameter int STALL_CYCLES = 3,
    localparam int CNT_W       = $clog2(STALL_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (start)      cnt_q <= CNT_W'(STALL_CYCLES);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R7: a start always produces a stall in the following cycle
    p_start_stalls_r7: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R7: the stall window never exceeds the configured length
    p_cnt_bounded_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(STALL_CYCLES));

endmodule

// File: rtl/enc_select_ctrl.sv
module enc_select_ctrl
    import enc_sel_pkg::*;
#(
    parameter int                NUM_SETS     = 4,
    parameter int                STALL_CYCLES = 3,
    parameter int                TVEC_W       = 32,
    parameter bit                WRITABLE     = 1'b1,
    parameter logic [ID_W-1:0]   VENDOR_BASE  = 16'h0A00,
    parameter logic [TVEC_W-1:0] TVEC_BASE    = 32'h1000_0000,
    parameter logic [TVEC_W-1:0] TVEC_STRIDE  = 32'h0000_0100,
    localparam int               IDX_W        = $clog2(NUM_SETS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                csr_we,
    input  logic [1:0]          csr_sel,
    input  logic [PAIR_W-1:0]   csr_wdata,
    output logic [PAIR_W-1:0]   csr_rdata,
    input  logic                trap_enter,
    input  logic                ctx_restore,
    input  logic [PAIR_W-1:0]   ctx_pair,
    output logic [NUM_SETS-1:0] dec_en,
    output logic [TVEC_W-1:0]   trap_base,
    output logic                switch_stall
);

    logic [IDX_W-1:0] sel_q;
    id_pair_t         cur_pair;
    id_pair_t         cand;
    csr_sel_e         sel_kind;
    logic             upd_req;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             accept;
    logic             changed;

    assign sel_kind = csr_sel_e'(csr_sel);
    assign cur_pair = entry_pair(VENDOR_BASE, int'(sel_q));

    // Resulting pair of this cycle's update; restore wins over a CSR write.
    always_comb begin
        cand = cur_pair;
        if (ctx_restore) begin
            cand = id_pair_t'(ctx_pair);
        end else begin
            unique case (sel_kind)
                SEL_VENDOR: cand.vendor = csr_wdata[ID_W-1:0];
                SEL_ARCH:   cand.arch   = csr_wdata[ID_W-1:0];
                SEL_PAIR:   cand        = id_pair_t'(csr_wdata);
                SEL_NONE:   cand        = cur_pair;
            endcase
        end
    end

    assign upd_req = WRITABLE && !trap_enter &&
                     (ctx_restore || (csr_we && sel_kind != SEL_NONE));

    enc_match #(
        .NUM_SETS   (NUM_SETS),
        .IDX_W      (IDX_W),
        .VENDOR_BASE(VENDOR_BASE)
    ) u_match (
        .cand(cand),
        .hit (hit),
        .idx (hit_idx)
    );

    assign accept  = upd_req && hit;
    assign changed = accept && (hit_idx != sel_q);

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= '0;
        else if (accept) sel_q <= hit_idx;
    end

    enc_vec_table #(
        .NUM_SETS   (NUM_SETS),
        .IDX_W      (IDX_W),
        .TVEC_W     (TVEC_W),
        .TVEC_BASE  (TVEC_BASE),
        .TVEC_STRIDE(TVEC_STRIDE)
    ) u_vec (
        .idx   (sel_q),
        .onehot(dec_en),
        .base  (trap_base)
    );

    enc_stall_timer #(
        .STALL_CYCLES(STALL_CYCLES)
    ) u_stall (
        .clk  (clk),
        .rst  (rst),
        .start(changed),
        .busy (switch_stall)
    );

    always_comb begin
        unique case (sel_kind)
            SEL_VENDOR: csr_rdata = {{(PAIR_W-ID_W){1'b0}}, cur_pair.vendor};
            SEL_ARCH:   csr_rdata = {{(PAIR_W-ID_W){1'b0}}, cur_pair.arch};
            SEL_PAIR:   csr_rdata = PAIR_W'(cur_pair);
            SEL_NONE:   csr_rdata = '0;
        endcase
    end

    // R3: the decoder enables stay mutually exclusive and never all low
    p_onehot_en_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(dec_en) == 1);

    // R8: trap entry freezes the selected pair
    p_trap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        trap_enter |=> $stable(sel_q));

    // R6: an update with no table match leaves the selection alone
    p_illegal_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_req && !hit) |=> $stable(sel_q));

    // R7: any change of selection is covered by the stall request
    p_switch_stalls_r7: assert property (@(posedge clk) disable iff (rst)
        (sel_q != $past(sel_q)) |-> switch_stall);

    // R7: rewriting the same entry outside a stall raises no stall
    p_same_no_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && !changed && !switch_stall) |=> !switch_stall);

    generate
        if (!WRITABLE) begin : g_ro_chk
            // R11: read-only build stays on the default encoding
            p_ro_fixed_r11: assert property (@(posedge clk) disable iff (rst)
                dec_en == NUM_SETS'(1));
        end
    endgenerate

endmodule

// File: tb/test_enc_select_ctrl.sv
module test_enc_select_ctrl;
    import enc_sel_pkg::*;

    localparam int NSETS = 4;
    localparam int STALL = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              csr_we = 1'b0;
    logic [1:0]        csr_sel = 2'd0;
    logic [31:0]       csr_wdata = '0;
    logic              trap_enter = 1'b0;
    logic              ctx_restore = 1'b0;
    logic [31:0]       ctx_pair = '0;
    logic [31:0]       csr_rdata, ro_rdata;
    logic [NSETS-1:0]  dec_en, ro_dec_en;
    logic [31:0]       trap_base, ro_base;
    logic              switch_stall, ro_stall;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5ns clk = ~clk;

    enc_select_ctrl i_enc_select_ctrl (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .trap_enter(trap_enter), .ctx_restore(ctx_restore), .ctx_pair(ctx_pair),
        .dec_en(dec_en), .trap_base(trap_base), .switch_stall(switch_stall)
    );

    enc_select_ctrl #(.WRITABLE(1'b0)) i_ro (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(ro_rdata),
        .trap_enter(trap_enter), .ctx_restore(ctx_restore), .ctx_pair(ctx_pair),
        .dec_en(ro_dec_en), .trap_base(ro_base), .switch_stall(ro_stall)
    );

    // Expected table, from the R2 rule
    function automatic logic [31:0] pair_of(input int i);
        return {16'h0A00 + 16'(i / 2), 16'(i)};
    endfunction
    function automatic logic [31:0] base_of(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h100;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_entry(input string req, input int i);
        chk(req, "dec_en", 32'(dec_en), 32'(1) << i);
        chk(req, "trap_base", trap_base, base_of(i));
        chk("R3", "onehot", 32'($countones(dec_en)), 32'd1);
    endtask

    // One-cycle CSR write; returns at the negedge after the capturing edge
    task automatic csr_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        csr_we = 1'b1; csr_sel = sel; csr_wdata = data;
        @(negedge clk);
        csr_we = 1'b0; csr_sel = 2'd2; csr_wdata = '0;
    endtask

    // Count consecutive stalled cycles starting at the current sample point
    task automatic count_stall(output int n);
        n = 0;
        while (switch_stall && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk_entry("R1", 0);
        chk("R1", "stall", 32'(switch_stall), 32'd0);
        csr_sel = 2'd2; #1;
        chk("R1", "pair read", csr_rdata, pair_of(0));
    endtask

    task automatic t_sweep;
        int n;
        int order[4] = '{1, 2, 3, 0};
        foreach (order[k]) begin
            csr_write(2'd2, pair_of(order[k]));
            chk_entry("R4", order[k]);
            chk("R2", "base formula", trap_base, base_of(order[k]));
            count_stall(n);
            chk("R7", "stall length", 32'(n), 32'(STALL));
        end
    endtask

    task automatic t_fields;
        int n;
        csr_write(2'd2, pair_of(2));
        count_stall(n);
        csr_write(2'd1, 32'h0000_0003);
        chk_entry("R5", 3);
        count_stall(n);
        chk("R5", "stall after arch write", 32'(n), 32'(STALL));
        csr_sel = 2'd0; #1;
        chk("R10", "vendor read", csr_rdata, 32'h0000_0A01);
        csr_sel = 2'd1; #1;
        chk("R10", "arch read", csr_rdata, 32'h0000_0003);
        csr_sel = 2'd3; #1;
        chk("R10", "none read", csr_rdata, 32'h0);
        csr_write(2'd0, 32'h0000_0A00);
        chk_entry("R6", 3);
        chk("R6", "stall half-illegal", 32'(switch_stall), 32'd0);
    endtask

    task automatic t_illegal;
        csr_write(2'd1, 32'h0000_0000);
        chk_entry("R6", 3);
        chk("R6", "stall", 32'(switch_stall), 32'd0);
        csr_write(2'd2, 32'h0A05_0000);
        chk_entry("R6", 3);
        csr_write(2'd3, pair_of(0));
        chk_entry("R6", 3);
        chk("R6", "stall sel3", 32'(switch_stall), 32'd0);
    endtask

    task automatic t_same;
        csr_write(2'd2, pair_of(3));
        chk_entry("R7", 3);
        chk("R7", "no stall on same pair", 32'(switch_stall), 32'd0);
    endtask

    task automatic t_trap;
        @(negedge clk);
        trap_enter = 1'b1; csr_we = 1'b1; csr_sel = 2'd2; csr_wdata = pair_of(0);
        @(negedge clk);
        trap_enter = 1'b0; csr_we = 1'b0;
        chk_entry("R8", 3);
        chk("R8", "stall", 32'(switch_stall), 32'd0);
        csr_sel = 2'd2; #1;
        chk("R8", "saved pair", csr_rdata, pair_of(3));
    endtask

    task automatic t_restore;
        int n;
        @(negedge clk);
        ctx_restore = 1'b1; ctx_pair = pair_of(1);
        csr_we = 1'b1; csr_sel = 2'd2; csr_wdata = pair_of(2);
        @(negedge clk);
        ctx_restore = 1'b0; csr_we = 1'b0;
        chk_entry("R9", 1);
        count_stall(n);
        chk("R9", "stall after restore", 32'(n), 32'(STALL));
        @(negedge clk);
        ctx_restore = 1'b1; ctx_pair = 32'h0BAD_0001;
        @(negedge clk);
        ctx_restore = 1'b0;
        chk_entry("R9", 1);
    endtask

    task automatic t_readonly;
        csr_write(2'd2, pair_of(2));
        chk("R11", "ro dec_en", 32'(ro_dec_en), 32'd1);
        chk("R11", "ro base", ro_base, base_of(0));
        chk("R11", "ro stall", 32'(ro_stall), 32'd0);
        csr_sel = 2'd2; #1;
        chk("R11", "ro read", ro_rdata, pair_of(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_sweep();
        t_fields();
        t_illegal();
        t_same();
        t_trap();
        t_restore();
        t_readonly();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule